// File: doc/BRIEF.md
# Sequential Lock Dependency Resolver

This block decides which feedback locks in a multi-lock optical setup must be held frozen because something they rely on has dropped out. Locks are grouped into sets of up to four slots. Inside a set the slots form a chain: a lock may act only while every lock in an earlier slot of the same set is locked. Sets themselves depend on other sets through an acyclic relation, and every lock in a set is frozen unless every lock in each set it depends on is locked. Manual freeze requests from the operator are merged with these automatic ones.

The assignment of locks to slots, the set-to-set dependency matrix and the number of locks in use are written through a small address/data register port. After each accepted write the block checks the configuration in hardware. Structural rules are checked combinationally. Dependency cycles are found with a reachability closure that runs for a fixed number of passes. Until the check ends, and whenever the configuration is rejected, every lock is frozen.

Top module: `lockdep_resolver`

## Requirements
- R1: After reset every slot is empty (lock index 31), no set depends on another, and the lock count is 16. During reset and on the first edge after it, `blocked_o` is all ones and `cfg_valid_o` is 0. The empty default configuration is reported valid no later than 10 clock edges after reset is released.
- R2: Within a set, the lock in slot k is blocked if any occupied slot before k holds a lock whose `locked_i` bit is 0. Empty slots in a set impose nothing.
- R3: Every lock of set s is blocked if any set t, with bit t of row s of the dependency matrix set, contains an occupied slot whose lock is unlocked.
- R4: A configuration in which set 0 depends on any set is rejected.
- R5: A configuration in which any lock index appears in more than one slot, within one set or across sets, is rejected.
- R6: A configuration in which an empty slot is followed by an occupied slot in the same set is rejected.
- R7: A configuration in which a set depends on itself, or in which the dependency relation has a cycle of any length, is rejected. Every accepted register write forces `cfg_valid_o` to 0 two edges later. The new verdict is due no later than 10 edges after the write edge.
- R8: A configuration is rejected if a slot holds an index at or above the configured lock count, or if the lock count exceeds 16.
- R9: While the configuration is valid, `blocked_o` is the bitwise OR of `manual_block_i` and the automatic blocks of R2 and R3. Locks not placed in any slot have no automatic block. While the configuration is not valid, `blocked_o` is all ones.
- R10: `set_locked_o[s]` is 1 when every occupied slot of set s holds a locked lock; an empty set counts as locked. `all_locked_o` is 1 only when the configuration is valid and every set is locked.
- R11: All four outputs are registered. A change on `locked_i` or `manual_block_i` shows on the outputs at the first clock edge after it.
- R12: Register map: addresses 0..7 write the four slots of set 0..7, with slot k at data bits [5k+4:5k] and 31 meaning empty. Addresses 8..15 write the dependency row of set 0..7, where data bit t means "depends on set t". Address 16 writes the lock count in data bits [4:0]. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 20 | Configuration write data |
| locked_i | input | 16 | Per-lock locked status |
| manual_block_i | input | 16 | Per-lock manual freeze request |
| blocked_o | output | 16 | Per-lock freeze command |
| set_locked_o | output | 8 | Per-set all-locked flag |
| all_locked_o | output | 1 | Every set locked and configuration valid |
| cfg_valid_o | output | 1 | Configuration accepted |

## Verification
Status and manual inputs go through one output register, so each status vector is driven at a falling edge and all four outputs are compared at the next falling edge, after exactly one rising edge. A configuration verdict takes one load pass, eight closure passes and the output register. The bench therefore waits 12 edges after every write before it compares, and it checks the forced invalid state two edges after a write. Expected values come from a model of the register map in the bench, which runs its own closure loop for cycle detection.

// File: rtl/lockdep_pkg.sv
package lockdep_pkg;
    localparam int NUM_LOCKS = 16;
    localparam int NUM_SETS  = 8;
    localparam int SLOTS     = 4;

    localparam int LW      = $clog2(NUM_LOCKS + 1);
    localparam int CW      = LW;
    localparam int SETW    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam int AW      = $clog2(2 * NUM_SETS + 1);
    localparam int SLOT_DW = SLOTS * LW;
    localparam int DW      = (SLOT_DW > NUM_SETS) ? ((SLOT_DW > CW) ? SLOT_DW : CW)
                                                  : ((NUM_SETS > CW) ? NUM_SETS : CW);
    localparam int CNTW    = $clog2(NUM_SETS + 1);
    localparam int PADW    = 2 ** LW;

    typedef logic [LW-1:0]                lock_idx_t;
    typedef lock_idx_t [SLOTS-1:0]        slot_row_t;
    typedef slot_row_t [NUM_SETS-1:0]     slot_map_t;
    typedef logic [NUM_SETS-1:0]          dep_row_t;
    typedef dep_row_t [NUM_SETS-1:0]      dep_mat_t;

    localparam lock_idx_t EMPTY_SLOT = '1;

    typedef enum logic [1:0] {
        REG_SLOTS,
        REG_DEPS,
        REG_COUNT,
        REG_NONE
    } reg_kind_e;

    function automatic reg_kind_e reg_kind(input logic [AW-1:0] a);
        if (int'(a) < NUM_SETS)       return REG_SLOTS;
        if (int'(a) < 2 * NUM_SETS)   return REG_DEPS;
        if (int'(a) == 2 * NUM_SETS)  return REG_COUNT;
        return REG_NONE;
    endfunction

    function automatic logic [SETW-1:0] reg_set(input logic [AW-1:0] a);
        int v;
        v = int'(a);
        if (v >= NUM_SETS) v = v - NUM_SETS;
        return SETW'(v);
    endfunction
endpackage

// File: rtl/lockdep_cfg.sv
module lockdep_cfg
    import lockdep_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output slot_map_t      slots_q,
    output dep_mat_t       deps_q,
    output logic [CW-1:0]  count_q,
    output logic           wr_start,
    output logic           struct_ok
);
    reg_kind_e kind;
    assign kind     = reg_kind(addr);
    assign wr_start = we && (kind != REG_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int k = 0; k < SLOTS; k++)
                    slots_q[s][k] <= EMPTY_SLOT;
            deps_q  <= '0;
            count_q <= CW'(NUM_LOCKS);
        end else if (we) begin
            case (kind)
                REG_SLOTS: slots_q[reg_set(addr)] <= slot_row_t'(wdata[SLOT_DW-1:0]);
                REG_DEPS:  deps_q[reg_set(addr)]  <= wdata[NUM_SETS-1:0];
                REG_COUNT: count_q                <= wdata[CW-1:0];
                default:   ;
            endcase
        end
    end

    // Structural rules: count range, root set, ordering of empties, duplicates.
    logic [PADW-1:0] seen;
    logic            gap;
    always_comb begin
        struct_ok = 1'b1;
        seen      = '0;
        gap       = 1'b0;
        if (int'(count_q) > NUM_LOCKS) struct_ok = 1'b0;
        if (deps_q[0] != '0)           struct_ok = 1'b0;
        for (int s = 0; s < NUM_SETS; s++) begin
            gap = 1'b0;
            for (int k = 0; k < SLOTS; k++) begin
                if (slots_q[s][k] == EMPTY_SLOT) begin
                    gap = 1'b1;
                end else begin
                    if (gap)                    struct_ok = 1'b0;
                    if (slots_q[s][k] >= count_q) struct_ok = 1'b0;
                    if (seen[slots_q[s][k]])    struct_ok = 1'b0;
                    seen[slots_q[s][k]] = 1'b1;
                end
            end
        end
    end

    a_r12_unused_addr_noop: assert property (@(posedge clk) disable iff (rst)
        (we && kind == REG_NONE) |=> ($stable(slots_q) && $stable(deps_q) && $stable(count_q)));
endmodule

// File: rtl/lockdep_cycle.sv
module lockdep_cycle
    import lockdep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  dep_mat_t deps,
    output logic     busy,
    output logic     has_cycle
);
    dep_mat_t          reach_q;
    dep_mat_t          reach_step;
    logic [CNTW-1:0]   cnt_q;

    // One closure pass: a set reaches everything its reachable sets reach.
    always_comb begin
        reach_step = reach_q;
        for (int i = 0; i < NUM_SETS; i++)
            for (int j = 0; j < NUM_SETS; j++)
                if (reach_q[i][j]) reach_step[i] = reach_step[i] | reach_q[j];
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            busy    <= 1'b1;
            cnt_q   <= '0;
            reach_q <= '0;
        end else if (busy) begin
            reach_q <= (cnt_q == '0) ? deps : reach_step;
            if (cnt_q == CNTW'(NUM_SETS)) busy <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        has_cycle = 1'b0;
        for (int i = 0; i < NUM_SETS; i++)
            if (reach_q[i][i]) has_cycle = 1'b1;
    end

    a_r7_write_restarts: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && cnt_q == '0));
    a_r1_pass_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= CNTW'(NUM_SETS)));
endmodule

// File: rtl/lockdep_eval.sv
module lockdep_eval
    import lockdep_pkg::*;
(
    input  slot_map_t             slots,
    input  dep_mat_t              deps,
    input  logic [NUM_LOCKS-1:0]  locked,
    input  logic [NUM_LOCKS-1:0]  manual,
    input  logic                  cfg_ok,
    output logic [NUM_LOCKS-1:0]  blocked_n,
    output logic [NUM_SETS-1:0]   set_locked_n,
    output logic                  all_locked_n
);
    logic [PADW-1:0]                   locked_pad;
    logic [NUM_SETS-1:0]               pre_ok;
    logic [NUM_SETS-1:0][SLOTS-1:0]    chain_ok;
    logic [NUM_LOCKS-1:0]              auto_blk;
    logic                              run;

    assign locked_pad = {{(PADW - NUM_LOCKS){1'b0}}, locked};

    always_comb begin
        set_locked_n = '1;
        pre_ok       = '1;
        chain_ok     = '1;
        auto_blk     = '0;
        run          = 1'b1;
        for (int s = 0; s < NUM_SETS; s++)
            for (int k = 0; k < SLOTS; k++)
                if (slots[s][k] != EMPTY_SLOT && !locked_pad[slots[s][k]])
                    set_locked_n[s] = 1'b0;
        for (int s = 0; s < NUM_SETS; s++) begin
            for (int t = 0; t < NUM_SETS; t++)
                if (deps[s][t] && !set_locked_n[t]) pre_ok[s] = 1'b0;
            run = 1'b1;
            for (int k = 0; k < SLOTS; k++) begin
                chain_ok[s][k] = run;
                if (slots[s][k] != EMPTY_SLOT) run = run & locked_pad[slots[s][k]];
            end
        end
        for (int l = 0; l < NUM_LOCKS; l++)
            for (int s = 0; s < NUM_SETS; s++)
                for (int k = 0; k < SLOTS; k++)
                    if (slots[s][k] == lock_idx_t'(l) && !(pre_ok[s] && chain_ok[s][k]))
                        auto_blk[l] = 1'b1;
    end

    assign blocked_n    = cfg_ok ? (manual | auto_blk) : '1;
    assign all_locked_n = cfg_ok && (&set_locked_n);
endmodule

// File: rtl/lockdep_resolver.sv
module lockdep_resolver
    import lockdep_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [AW-1:0]         cfg_addr,
    input  logic [DW-1:0]         cfg_wdata,
    input  logic [NUM_LOCKS-1:0]  locked_i,
    input  logic [NUM_LOCKS-1:0]  manual_block_i,
    output logic [NUM_LOCKS-1:0]  blocked_o,
    output logic [NUM_SETS-1:0]   set_locked_o,
    output logic                  all_locked_o,
    output logic                  cfg_valid_o
);
    slot_map_t             slots;
    dep_mat_t              deps;
    logic [CW-1:0]         count;
    logic                  wr_start, struct_ok, busy, has_cycle, cfg_ok;
    logic [NUM_LOCKS-1:0]  blocked_n;
    logic [NUM_SETS-1:0]   set_locked_n;
    logic                  all_locked_n;

    lockdep_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .slots_q(slots), .deps_q(deps), .count_q(count),
        .wr_start(wr_start), .struct_ok(struct_ok)
    );

    lockdep_cycle u_cycle (
        .clk(clk), .rst(rst), .start(wr_start), .deps(deps),
        .busy(busy), .has_cycle(has_cycle)
    );

    assign cfg_ok = !busy && !has_cycle && struct_ok;

    lockdep_eval u_eval (
        .slots(slots), .deps(deps), .locked(locked_i), .manual(manual_block_i),
        .cfg_ok(cfg_ok), .blocked_n(blocked_n), .set_locked_n(set_locked_n),
        .all_locked_n(all_locked_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked_o    <= '1;
            set_locked_o <= '0;
            all_locked_o <= 1'b0;
            cfg_valid_o  <= 1'b0;
        end else begin
            blocked_o    <= blocked_n;
            set_locked_o <= set_locked_n;
            all_locked_o <= all_locked_n;
            cfg_valid_o  <= cfg_ok;
        end
    end

    a_r9_manual_blocks: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((blocked_o & $past(manual_block_i)) == $past(manual_block_i)));
    a_r9_invalid_blocks_all: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid_o |-> (&blocked_o));
    a_r10_all_needs_sets: assert property (@(posedge clk) disable iff (rst)
        all_locked_o |-> ((&set_locked_o) && cfg_valid_o));
    a_r7_write_drops_valid: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> ##2 !cfg_valid_o);
endmodule

// File: tb/lockdep_resolver_tb.sv
`timescale 1ns/1ps
module lockdep_resolver_tb;
    import lockdep_pkg::*;

    localparam int E = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [NUM_LOCKS-1:0] locked_i = '0;
    logic [NUM_LOCKS-1:0] manual_block_i = '0;
    logic [NUM_LOCKS-1:0] blocked_o;
    logic [NUM_SETS-1:0]  set_locked_o;
    logic all_locked_o, cfg_valid_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int m_slot [NUM_SETS][SLOTS];
    logic [NUM_SETS-1:0] m_dep [NUM_SETS];
    int m_count;

    always #10 clk = ~clk;

    lockdep_resolver u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .locked_i(locked_i), .manual_block_i(manual_block_i), .blocked_o(blocked_o),
        .set_locked_o(set_locked_o), .all_locked_o(all_locked_o), .cfg_valid_o(cfg_valid_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_valid();
        bit ok = 1;
        bit seen [int];
        logic [NUM_SETS-1:0] r [NUM_SETS];
        if (m_count > NUM_LOCKS) ok = 0;
        if (m_dep[0] != 0) ok = 0;
        for (int s = 0; s < NUM_SETS; s++) begin
            bit hole = 0;
            for (int k = 0; k < SLOTS; k++) begin
                int v = m_slot[s][k];
                if (v == E) hole = 1;
                else begin
                    if (hole || v >= m_count || seen.exists(v)) ok = 0;
                    seen[v] = 1;
                end
            end
        end
        for (int i = 0; i < NUM_SETS; i++) r[i] = m_dep[i];
        for (int p = 0; p < NUM_SETS; p++)
            for (int i = 0; i < NUM_SETS; i++)
                for (int j = 0; j < NUM_SETS; j++)
                    if (r[i][j]) r[i] = r[i] | r[j];
        for (int i = 0; i < NUM_SETS; i++) if (r[i][i]) ok = 0;
        return ok;
    endfunction

    task automatic cfg_write(input int a, input logic [DW-1:0] d);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < NUM_SETS) begin
            for (int k = 0; k < SLOTS; k++) m_slot[a][k] = int'(d[LW*k +: LW]);
        end else if (a < 2*NUM_SETS) m_dep[a-NUM_SETS] = d[NUM_SETS-1:0];
        else if (a == 2*NUM_SETS) m_count = int'(d[CW-1:0]);
    endtask

    task automatic set_slots(input int s, input int a, input int b, input int c, input int d);
        logic [DW-1:0] w = '0;
        int v [4];
        v = '{a, b, c, d};
        for (int k = 0; k < SLOTS; k++) w[LW*k +: LW] = LW'(v[k]);
        cfg_write(s, w);
    endtask

    task automatic settle();
        repeat (NUM_SETS + 4) @(negedge clk);
    endtask

    task automatic apply(input logic [NUM_LOCKS-1:0] lk, input logic [NUM_LOCKS-1:0] mb, input string tag);
        bit v;
        logic [NUM_SETS-1:0] sl;
        logic [NUM_LOCKS-1:0] au, eb;
        bit eall;
        locked_i = lk; manual_block_i = mb;
        @(negedge clk);
        v = m_valid();
        au = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            sl[s] = 1;
            for (int k = 0; k < SLOTS; k++) begin
                int x = m_slot[s][k];
                if (x != E) sl[s] = sl[s] & ((x < NUM_LOCKS) ? lk[x] : 1'b0);
            end
        end
        for (int s = 0; s < NUM_SETS; s++) begin
            bit pre = 1, ch = 1;
            for (int t = 0; t < NUM_SETS; t++) if (m_dep[s][t] && !sl[t]) pre = 0;
            for (int k = 0; k < SLOTS; k++) begin
                int x = m_slot[s][k];
                if (x != E && x < NUM_LOCKS) begin
                    if (!pre || !ch) au[x] = 1;
                    ch = ch & lk[x];
                end
            end
        end
        eb = v ? (mb | au) : '1;
        eall = v && (&sl);
        check(cfg_valid_o == v, {tag, " valid"}, 32'(cfg_valid_o), 32'(v));
        check(blocked_o == eb, {tag, " blocked"}, 32'(blocked_o), 32'(eb));
        check(set_locked_o == sl, {tag, " set_locked"}, 32'(set_locked_o), 32'(sl));
        check(all_locked_o == eall, {tag, " all_locked"}, 32'(all_locked_o), 32'(eall));
    endtask

    task automatic load_base();
        for (int s = 0; s < NUM_SETS; s++) set_slots(s, E, E, E, E);
        for (int s = 0; s < NUM_SETS; s++) cfg_write(NUM_SETS + s, '0);
        cfg_write(2*NUM_SETS, DW'(NUM_LOCKS));
        set_slots(0, 0, 1, 2, 3);
        set_slots(1, 4, 5, E, E);
        set_slots(2, 6, E, E, E);
        set_slots(3, 7, 8, E, E);
        cfg_write(NUM_SETS + 1, DW'(8'b0000_0001));
        cfg_write(NUM_SETS + 2, DW'(8'b0000_0011));
        cfg_write(NUM_SETS + 3, DW'(8'b0000_0100));
        settle();
    endtask

    task automatic random_cfg();
        int perm [NUM_LOCKS];
        int p = 0;
        for (int i = 0; i < NUM_LOCKS; i++) perm[i] = i;
        for (int i = NUM_LOCKS-1; i > 0; i--) begin
            int j = $urandom % (i+1);
            int t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        end
        cfg_write(2*NUM_SETS, DW'(NUM_LOCKS));
        for (int s = 0; s < NUM_SETS; s++) begin
            int n = $urandom % (SLOTS+1);
            int v [4] = '{E, E, E, E};
            for (int k = 0; k < n && p < NUM_LOCKS; k++) begin v[k] = perm[p]; p++; end
            set_slots(s, v[0], v[1], v[2], v[3]);
            cfg_write(NUM_SETS + s, DW'($urandom & ((1 << s) - 1)));
        end
        settle();
    endtask

    initial begin
        for (int s = 0; s < NUM_SETS; s++) begin
            m_dep[s] = '0;
            for (int k = 0; k < SLOTS; k++) m_slot[s][k] = E;
        end
        m_count = NUM_LOCKS;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(blocked_o == '1, "R1 blocked in reset", 32'(blocked_o), 32'hFFFF);
        check(cfg_valid_o == 1'b0, "R1 valid in reset", 32'(cfg_valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(blocked_o == '1, "R1 blocked after reset", 32'(blocked_o), 32'hFFFF);
        check(cfg_valid_o == 1'b0, "R1 checking after reset", 32'(cfg_valid_o), 0);
        repeat (NUM_SETS + 1) @(negedge clk);
        // R1 / R10: empty default configuration, every set locked
        apply('0, 16'h0000, "R1 R10 empty cfg");
        apply('0, 16'hA5C3, "R9 manual only");

        load_base();
        apply('1, '0, "R10 all locked");
        apply(16'hFFFD, '0, "R2 chain slot1 down");
        apply(16'hFFF7, '0, "R2 last slot down");
        apply(16'hFFEF, '0, "R3 set1 head down");
        apply(16'hFFBF, 16'h8000, "R3 R9 set2 down with manual");
        apply(16'hFEFF, '0, "R2 R3 set3 tail");
        // R11: one-edge response on consecutive changes
        apply(16'hFFFE, '0, "R11 root head down");
        apply('1, 16'h0001, "R11 recovered");

        // R7: write forces invalid two edges later
        cfg_write(NUM_SETS + 1, DW'(8'b0000_0001));
        @(negedge clk);
        check(cfg_valid_o == 1'b0, "R7 recheck after write", 32'(cfg_valid_o), 0);
        check(blocked_o == '1, "R7 R9 blocked during recheck", 32'(blocked_o), 32'hFFFF);
        settle();
        apply('1, '0, "R7 verdict restored");

        // R4
        cfg_write(NUM_SETS + 0, DW'(8'b0000_0010)); settle();
        apply('1, '0, "R4 root dependency");
        load_base();
        // R5
        set_slots(4, 3, E, E, E); settle();
        apply('1, '0, "R5 duplicate across sets");
        set_slots(4, 9, 9, E, E); settle();
        apply('1, '0, "R5 duplicate in set");
        // R6
        set_slots(4, E, 9, E, E); settle();
        apply('1, '0, "R6 gap before slot");
        set_slots(4, 9, 10, E, E); settle();
        apply('1, '0, "R6 no gap accepted");
        load_base();
        // R7
        cfg_write(NUM_SETS + 5, DW'(8'b0010_0000)); settle();
        apply('1, '0, "R7 self dependency");
        load_base();
        cfg_write(NUM_SETS + 1, DW'(8'b0000_1001)); settle();
        apply('1, '0, "R7 three set cycle");
        load_base();
        // R8
        cfg_write(2*NUM_SETS, DW'(8)); settle();
        apply('1, '0, "R8 index above count");
        cfg_write(2*NUM_SETS, DW'(9)); settle();
        apply('1, '0, "R8 count just enough");
        cfg_write(2*NUM_SETS, DW'(17)); settle();
        apply('1, '0, "R8 count too large");
        load_base();
        // R12: unused address ignored
        cfg_write(2*NUM_SETS + 3, '1); settle();
        apply(16'hFFFD, '0, "R12 unused address");
        apply('1, '0, "R12 unused address all locked");

        // Random configurations and status patterns
        for (int c = 0; c < 25; c++) begin
            random_cfg();
            for (int v = 0; v < 20; v++) begin
                logic [NUM_LOCKS-1:0] lk = NUM_LOCKS'($urandom);
                if (v % 3 == 0) lk = lk | NUM_LOCKS'($urandom);
                if (v % 5 == 0) lk = '1;
                apply(lk, NUM_LOCKS'($urandom) & NUM_LOCKS'($urandom) & NUM_LOCKS'($urandom),
                      "R2 R3 R9 R10 random");
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule